// File: doc/BRIEF.md
# Reset Sequencing Controller

This block collects every reset request of a small microcontroller and turns them into one timed reset event. It produces the core reset that holds the CPU and memories, a gate that keeps module clocks stopped while the oscillator settles, an open-drain drive for the bidirectional board-level reset pin, and a one-cycle strobe that starts the reset-vector fetch. All timing is counted on the fast bus clock. The analog detectors, the oscillator and the watchdog counter sit outside and arrive here only as request pulses.

Power-on and low-voltage events use the long path: a stabilisation window with module clocks stopped and the pin driven, a short extra pin-drive window, then a release window. Watchdog, illegal-opcode, illegal-address and mode-entry requests skip stabilisation and only pulse the pin. A pin pulled low by another device is itself treated as a reset. A cause register keeps a single bit naming the source of the latest reset. The power-on request doubles as the block's asynchronous reset. The block has no streaming data path; every pin is a plain level or pulse with no handshake and no back-pressure.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `por_req` is high, `core_rst` and `pin_drive_low` are high, `clk_en` and `vec_fetch` are low and `rst_cause` reads 7'b0000001, independent of the clock.
- R2: After `por_req` falls, or after `lvd_req` is taken while idle, `clk_en` stays low for STAB_CYC (4096) cycles and `pin_drive_low` stays high for STAB_CYC+DRV_CYC (4128) cycles.
- R3: In the release phase `core_rst` falls on the REL_CYC-1 (31st) rising edge after the first edge that samples `pin_in` high; at that edge `vec_fetch` rises for exactly one cycle with `core_rst` low, and the block then returns to idle.
- R4: A watchdog, illegal-opcode, illegal-address or mode-entry reset drives `pin_drive_low` for DRV_CYC (32) cycles starting at the edge that takes the request, keeps `clk_en` high throughout, and then releases as in R3.
- R5: A watchdog pulse on `wdog_req_async` shorter than a clock period, falling before the next rising edge, is captured, and the reset starts on the third rising edge after the pulse.
- R6: Each reset loads `rst_cause` with exactly one set bit for its cause and clears the rest; bit 0 power-on, 1 low-voltage, 2 watchdog, 3 illegal opcode, 4 illegal address, 5 mode entry, 6 external pin.
- R7: When several requests are seen at the same idle edge, low-voltage wins over watchdog, watchdog over illegal opcode, then illegal address, then mode entry, then the external pin.
- R8: Requests other than power-on that arrive while a reset is in progress are dropped: `rst_cause` and the timing of all outputs stay as if they had not occurred.
- R9: A `por_req` pulse in any phase restarts the sequence at stabilisation, with the full R2 and R3 timing counted from its falling edge.
- R10: If `pin_in` is still low when the block stops driving, `core_rst` stays high until the pin reads high and then falls per R3.
- R11: `pin_in` low while idle (low means asserted) starts a reset with `rst_cause` = 7'b1000000, sampled through a two-flop synchroniser so the reset begins on the second edge after the first low sample; the block does not drive the pin for it, and release follows R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast bus clock that all timing is counted on |
| por_req | input | 1 | Power-on request, active high, also the asynchronous reset |
| lvd_req | input | 1 | Low-voltage request, synchronous pulse |
| wdog_req_async | input | 1 | Watchdog timeout pulse, asynchronous to the clock |
| bad_opcode_req | input | 1 | Illegal-opcode request, synchronous pulse |
| bad_addr_req | input | 1 | Illegal-address request, synchronous pulse |
| mode_rst_req | input | 1 | Mode-entry reset request, synchronous pulse |
| pin_in | input | 1 | Level sensed on the external reset pin, low = asserted |
| pin_drive_low | output | 1 | Open-drain enable, high pulls the external pin low |
| core_rst | output | 1 | Internal reset to CPU and memories |
| clk_en | output | 1 | Enable for CPU and module clocks, low while the oscillator settles |
| vec_fetch | output | 1 | One-cycle strobe that starts the reset-vector fetch |
| rst_cause | output | 7 | One-hot code of the latest reset source |

## Verification
The embedded properties watch relations that must hold in every cycle: the pin is never driven outside core reset, stopped clocks always coincide with pin drive, the vector strobe lasts one cycle and only follows core reset, the cause register holds a single bit and never changes in the middle of a sequence, and a pin-originated reset never drives the pin. Exact phase lengths, the three-edge watchdog latency, priority among simultaneous requests, requests dropped while busy, a pin held low by another device and a power-on restart in mid-sequence can only be shown by the bench scenarios, where a behavioural model predicts every output on every cycle.

// File: rtl/rst_seq_pkg.sv
`timescale 1ns/1ps
package rst_seq_pkg;
  localparam int NCAUSE = 7;
  // Cause index doubles as priority rank: a lower index wins.
  localparam int C_POR  = 0;
  localparam int C_LVD  = 1;
  localparam int C_WDOG = 2;
  localparam int C_OPC  = 3;
  localparam int C_ADDR = 4;
  localparam int C_MODE = 5;
  localparam int C_PIN  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_STAB,
    ST_DRIVE,
    ST_REL,
    ST_VEC
  } seq_state_e;
endpackage

// File: rtl/rst_sync_chain.sv
`timescale 1ns/1ps
module rst_sync_chain #(
  parameter int   STAGES = 2,
  parameter logic INIT   = 1'b0
) (
  input  logic clk,
  input  logic clr,
  input  logic d,
  output logic q
);
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic q_r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk or posedge clr) begin
        if (clr) q_r <= INIT;
        else     q_r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or posedge clr) begin
        if (clr) q_r <= INIT;
        else     q_r <= g_stage[i-1].q_r;
      end
    end
  end

  assign q = g_stage[STAGES-1].q_r;
endmodule

// File: rtl/rst_async_capture.sv
`timescale 1ns/1ps
module rst_async_capture #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic clr,
  input  logic req_async,
  output logic req_sync
);
  logic held;

  // Set without the clock so a pulse narrower than a period is kept;
  // cleared once the synchronised copy has been seen.
  always_ff @(posedge clk or posedge clr or posedge req_async) begin
    if (clr)            held <= 1'b0;
    else if (req_async) held <= 1'b1;
    else if (req_sync)  held <= 1'b0;
  end

  rst_sync_chain #(.STAGES(STAGES), .INIT(1'b0)) u_chain (
    .clk (clk),
    .clr (clr),
    .d   (held),
    .q   (req_sync)
  );

  p_capture_seen_r5: assert property (@(posedge clk) disable iff (clr)
    $fell(held) |-> $past(req_sync));
endmodule

// File: rtl/rst_cause_arbiter.sv
`timescale 1ns/1ps
module rst_cause_arbiter #(
  parameter int N = 7
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) grant = N'(1) << i;
    end
  end

  assign any = |req;
endmodule

// File: rtl/rst_seq_fsm.sv
`timescale 1ns/1ps
module rst_seq_fsm
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC = 4096,
  parameter int DRV_CYC  = 32,
  parameter int REL_CYC  = 32,
  parameter int SYNC_LAT = 2
) (
  input  logic              clk,
  input  logic              por_req,
  input  logic [NCAUSE-1:0] grant,
  input  logic              grant_any,
  input  logic              pin_sync,
  output logic              core_rst,
  output logic              pin_drive_low,
  output logic              clk_en,
  output logic              vec_fetch,
  output logic [NCAUSE-1:0] status
);
  localparam int CMAX_A = (STAB_CYC > DRV_CYC) ? STAB_CYC : DRV_CYC;
  localparam int CMAX   = (CMAX_A > REL_CYC) ? CMAX_A : REL_CYC;
  localparam int CW     = $clog2(CMAX + 1);
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_CYC - 1);
  localparam logic [CW-1:0] DRV_LAST  = CW'(DRV_CYC - 1);
  localparam logic [CW-1:0] REL_LAST  = CW'(REL_CYC - 1);
  localparam logic [CW-1:0] GRACE     = CW'(SYNC_LAT);
  localparam logic [NCAUSE-1:0] POR_ONLY = NCAUSE'(1) << C_POR;

  seq_state_e     st;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or posedge por_req) begin
    if (por_req) begin
      st     <= ST_STAB;
      cnt    <= '0;
      status <= POR_ONLY;
    end else begin
      case (st)
        ST_IDLE: begin
          if (grant_any) begin
            status <= grant;
            cnt    <= '0;
            if (grant[C_LVD])      st <= ST_STAB;
            else if (grant[C_PIN]) st <= ST_REL;
            else                   st <= ST_DRIVE;
          end
        end
        ST_STAB: begin
          if (cnt == STAB_LAST) begin
            st  <= ST_DRIVE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_DRIVE: begin
          if (cnt == DRV_LAST) begin
            st  <= ST_REL;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_REL: begin
          // The first SYNC_LAT counts cover the synchroniser lag; after
          // that a low pin freezes the count until it reads high.
          if (cnt >= GRACE && !pin_sync) cnt <= cnt;
          else if (cnt == REL_LAST) begin
            st  <= ST_VEC;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        ST_VEC:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    core_rst      = (st == ST_STAB) || (st == ST_DRIVE) || (st == ST_REL);
    pin_drive_low = (st == ST_STAB) || (st == ST_DRIVE);
    clk_en        = (st != ST_STAB);
    vec_fetch     = (st == ST_VEC);
  end

  p_drive_in_reset_r1: assert property (@(posedge clk) disable iff (por_req)
    pin_drive_low |-> core_rst);
  p_gate_with_drive_r2: assert property (@(posedge clk) disable iff (por_req)
    !clk_en |-> pin_drive_low);
  p_vec_after_reset_r3: assert property (@(posedge clk) disable iff (por_req)
    $rose(vec_fetch) |-> $past(core_rst));
  p_vec_single_r3: assert property (@(posedge clk) disable iff (por_req)
    vec_fetch |=> !vec_fetch);
  p_cause_onehot_r6: assert property (@(posedge clk) disable iff (por_req)
    $countones(status) == 1);
  p_cause_frozen_r8: assert property (@(posedge clk) disable iff (por_req)
    (core_rst && $past(core_rst)) |-> $stable(status));
  p_pin_reset_no_drive_r11: assert property (@(posedge clk) disable iff (por_req)
    status[C_PIN] |-> !pin_drive_low);
endmodule

// File: rtl/rst_seq_ctrl.sv
`timescale 1ns/1ps
module rst_seq_ctrl
  import rst_seq_pkg::*;
#(
  parameter int STAB_CYC    = 4096,
  parameter int DRV_CYC     = 32,
  parameter int REL_CYC     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_fast,
  input  logic              por_req,
  input  logic              lvd_req,
  input  logic              wdog_req_async,
  input  logic              bad_opcode_req,
  input  logic              bad_addr_req,
  input  logic              mode_rst_req,
  input  logic              pin_in,
  output logic              pin_drive_low,
  output logic              core_rst,
  output logic              clk_en,
  output logic              vec_fetch,
  output logic [NCAUSE-1:0] rst_cause
);
  logic              wdog_sync;
  logic              pin_sync;
  logic [NCAUSE-1:0] req_vec;
  logic [NCAUSE-1:0] grant;
  logic              grant_any;

  rst_async_capture #(.STAGES(SYNC_STAGES)) u_wdog_cap (
    .clk       (clk_fast),
    .clr       (por_req),
    .req_async (wdog_req_async),
    .req_sync  (wdog_sync)
  );

  rst_sync_chain #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_pin_sync (
    .clk (clk_fast),
    .clr (por_req),
    .d   (pin_in),
    .q   (pin_sync)
  );

  always_comb begin
    req_vec         = '0;
    req_vec[C_LVD]  = lvd_req;
    req_vec[C_WDOG] = wdog_sync;
    req_vec[C_OPC]  = bad_opcode_req;
    req_vec[C_ADDR] = bad_addr_req;
    req_vec[C_MODE] = mode_rst_req;
    req_vec[C_PIN]  = !pin_sync;
  end

  rst_cause_arbiter #(.N(NCAUSE)) u_arb (
    .req   (req_vec),
    .grant (grant),
    .any   (grant_any)
  );

  rst_seq_fsm #(
    .STAB_CYC (STAB_CYC),
    .DRV_CYC  (DRV_CYC),
    .REL_CYC  (REL_CYC),
    .SYNC_LAT (SYNC_STAGES)
  ) u_fsm (
    .clk           (clk_fast),
    .por_req       (por_req),
    .grant         (grant),
    .grant_any     (grant_any),
    .pin_sync      (pin_sync),
    .core_rst      (core_rst),
    .pin_drive_low (pin_drive_low),
    .clk_en        (clk_en),
    .vec_fetch     (vec_fetch),
    .status        (rst_cause)
  );
endmodule

// File: tb/rst_seq_ctrl_bench.sv
`timescale 1ns/1ps
module rst_seq_ctrl_bench;
  localparam int STAB = 4096;
  localparam int DRV  = 32;
  localparam int REL  = 32;
  localparam int P_IDLE = 0, P_STAB = 1, P_DRV = 2, P_REL = 3, P_VEC = 4;

  logic clk = 1'b0;
  logic por = 1'b0;
  logic lvd = 1'b0, wdog = 1'b0, opc = 1'b0, addr = 1'b0, mode = 1'b0;
  logic ext_hold = 1'b0;
  logic pin_in;
  logic pin_drive_low, core_rst, clk_en, vec_fetch;
  logic [6:0] rst_cause;

  int nchk = 0;
  int nfail = 0;
  string cur_tag = "R1";

  always #2 clk = ~clk;

  assign pin_in = !(pin_drive_low | ext_hold);

  rst_seq_ctrl u_rst_seq_ctrl (
    .clk_fast       (clk),
    .por_req        (por),
    .lvd_req        (lvd),
    .wdog_req_async (wdog),
    .bad_opcode_req (opc),
    .bad_addr_req   (addr),
    .mode_rst_req   (mode),
    .pin_in         (pin_in),
    .pin_drive_low  (pin_drive_low),
    .core_rst       (core_rst),
    .clk_en         (clk_en),
    .vec_fetch      (vec_fetch),
    .rst_cause      (rst_cause)
  );

  // Behavioural reference model
  int         m_phase = P_STAB;
  int         m_n = 0;
  int         m_k = 0;
  bit         m_seen = 1'b0;
  logic [6:0] m_stat = 7'b0000001;
  bit         smp1 = 1'b1, smp2 = 1'b1;
  int         wd_age = 100;
  bit         cur_smp, pin_vis, wd_vis;

  function automatic bit m_drive();
    return (m_phase == P_STAB) || (m_phase == P_DRV);
  endfunction

  always @(posedge clk or posedge por) begin
    if (por) begin
      m_phase = P_STAB; m_n = 0; m_k = 0; m_seen = 1'b0;
      m_stat = 7'b0000001; smp1 = 1'b1; smp2 = 1'b1; wd_age = 100;
    end else begin
      cur_smp = !(m_drive() | ext_hold);
      pin_vis = smp2;
      smp2 = smp1;
      smp1 = cur_smp;
      wd_vis = (wd_age >= 2) && (wd_age <= 4);
      if (wd_age < 100) wd_age++;
      case (m_phase)
        P_IDLE: begin
          m_n = 0; m_seen = 1'b0; m_k = 0;
          if (lvd)           begin m_phase = P_STAB; m_stat = 7'b0000010; end
          else if (wd_vis)   begin m_phase = P_DRV;  m_stat = 7'b0000100; end
          else if (opc)      begin m_phase = P_DRV;  m_stat = 7'b0001000; end
          else if (addr)     begin m_phase = P_DRV;  m_stat = 7'b0010000; end
          else if (mode)     begin m_phase = P_DRV;  m_stat = 7'b0100000; end
          else if (!pin_vis) begin m_phase = P_REL;  m_stat = 7'b1000000; end
        end
        P_STAB: begin
          m_n++;
          if (m_n == STAB) begin m_phase = P_DRV; m_n = 0; end
        end
        P_DRV: begin
          m_n++;
          if (m_n == DRV) begin m_phase = P_REL; m_seen = 1'b0; m_k = 0; end
        end
        P_REL: begin
          if (m_seen) begin
            m_k++;
            if (m_k == REL - 1) m_phase = P_VEC;
          end else if (cur_smp) begin
            m_seen = 1'b1; m_k = 0;
          end
        end
        default: m_phase = P_IDLE;
      endcase
    end
  end

  task automatic chk(input logic got, input logic exp, input string what);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %0b expected %0b at %0t", cur_tag, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    chk(core_rst, m_phase inside {P_STAB, P_DRV, P_REL}, "core_rst");
    chk(pin_drive_low, m_drive(), "pin_drive_low");
    chk(clk_en, m_phase != P_STAB, "clk_en");
    chk(vec_fetch, m_phase == P_VEC, "vec_fetch");
    nchk++;
    if (rst_cause !== m_stat) begin
      nfail++;
      $display("FAIL %s rst_cause actual %b expected %b at %0t", cur_tag, rst_cause, m_stat, $time);
    end
  end

  task automatic fire(input bit f_lvd, input bit f_opc, input bit f_addr, input bit f_mode);
    @(negedge clk); #1;
    lvd = f_lvd; opc = f_opc; addr = f_addr; mode = f_mode;
    @(negedge clk); #1;
    lvd = 1'b0; opc = 1'b0; addr = 1'b0; mode = 1'b0;
  endtask

  task automatic wd_pulse();
    @(negedge clk); #0.5;
    wdog = 1'b1; wd_age = 0;
    #0.3 wdog = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_phase != P_IDLE) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    #800000;
    nfail++;
    $display("FAIL watchdog %s actual timeout expected idle", cur_tag);
    summary();
    $finish;
  end

  initial begin
    #1 por = 1'b1;
    cur_tag = "R1";
    repeat (3) @(negedge clk);
    #1 por = 1'b0;
    cur_tag = "R2 R3";
    wait_idle();

    cur_tag = "R4 R6";
    fire(0, 1, 0, 0); wait_idle();
    fire(0, 0, 1, 0); wait_idle();
    fire(0, 0, 0, 1); wait_idle();

    cur_tag = "R5 R6";
    wd_pulse(); repeat (6) @(negedge clk); wait_idle();

    cur_tag = "R2 R6";
    fire(1, 0, 0, 0); wait_idle();

    cur_tag = "R7";
    fire(1, 1, 0, 1); wait_idle();
    fire(0, 1, 1, 0); wait_idle();
    fire(0, 0, 1, 1); wait_idle();

    cur_tag = "R8";
    fire(0, 1, 0, 0);
    repeat (5) @(negedge clk);
    fire(1, 0, 0, 0);
    repeat (5) @(negedge clk);
    fire(0, 0, 1, 0);
    wd_pulse();
    wait_idle();

    cur_tag = "R10";
    fire(0, 0, 0, 1);
    repeat (10) @(negedge clk);
    #1 ext_hold = 1'b1;
    while (m_phase != P_REL) @(negedge clk);
    repeat (20) @(negedge clk);
    #1 ext_hold = 1'b0;
    wait_idle();

    cur_tag = "R11";
    @(negedge clk); #1 ext_hold = 1'b1;
    repeat (20) @(negedge clk);
    #1 ext_hold = 1'b0;
    wait_idle();

    cur_tag = "R9";
    fire(0, 0, 1, 0);
    repeat (15) @(negedge clk);
    #1 por = 1'b1;
    repeat (2) @(negedge clk);
    #1 por = 1'b0;
    wait_idle();

    summary();
    $finish;
  end
endmodule